// File: doc/BRIEF.md
# ADC Conversion Sequencer with Power Hold

This block is the digital sequencer in front of a multiplexed 12-bit converter core. It accepts two kinds of work. The first is an on-demand software conversion: software picks a channel, enables the software path and writes a start bit. The second is a set of periodic automatic slots, each with its own channel, an enable and a run bit. For each job the sequencer waits an acquisition (settling) time, then pulses a start strobe to the core together with the channel. It takes the core's done strobe and its 12-bit code. Software results go into a low and a high byte, and a maskable one-cycle end-of-conversion interrupt follows. Results from the automatic slots go into one register per slot.

The sequencer is built so that it cannot stall. If a job's own enable disappears during acquisition, the job is dropped at once. If it disappears while the core is converting, the sequencer waits for the core to finish, throws the code away and returns to idle. A power-hold input keeps the converter powered while the sequencer is idle. This lets software stop automatic conversions safely: assert the hold, clear the run bits, wait, then release the hold. None of these steps leaves the sequencer busy.

Top module: `adc_seq_ctrl`

## Requirements
- R1: When `sw_start_wr` is pulsed while `sw_en` is 1, the sequencer launches a software conversion. The `core_start` pulse carries `core_chan` equal to the `sw_chan` sampled at launch.
- R2: `core_start` is a single-cycle pulse. A job spends ACQ_CLKS (16) cycles in acquisition, or ACQ_EXT_CLKS (64) for a software job while `ext_delay` is 1. From the edge that samples the start write, `core_start` appears after acquisition + 2 edges. Automatic slots always use the short acquisition time.
- R3: On the edge after `core_done` ends a software job, `sw_res_lo` takes code bits 7..0 and `sw_res_hi` takes code bits 11..8 in bits 3..0, with bits 7..4 at 0. The two bytes change at no other time.
- R4: `eoc_irq` pulses high for one cycle after each completed software job, provided `eoc_mask` was 0 on the completing edge. Automatic jobs never raise it.
- R5: `avail` is 0 from the edge that launches a job until the edge on which the sequencer returns to idle, and 1 otherwise.
- R6: `pwr_on` is 1 whenever `force_on` is 1 or a job is in progress, and 0 otherwise.
- R7: `start_bit` is set by a start write only while `sw_en` is 1. A start write with `sw_en` at 0 is ignored. The bit stays set until its job completes. Clearing `sw_en` clears the bit and cancels any software job, and the result bytes stay unchanged.
- R8: Automatic slot k runs when `auto_en[k]` and `auto_run[k]` are both 1. Every AUTO_PERIOD (200) cycles while any slot runs, each running slot gets one request. Its code goes to `auto_res[k*12 +: 12]`.
- R9: At idle, a pending software start wins over pending automatic requests, and a lower-numbered slot wins over a higher one.
- R10: Clearing a slot's run or enable bit during its job drops the job. The sequencer goes idle at once during acquisition, or on the core's done strobe during conversion. The code is discarded, and later conversions give correct results.
- R11: The stop sequence never leaves the sequencer busy: `force_on` = 1, both run bits cleared, a wait, then `force_on` = 0. Afterwards `avail` = 1, `pwr_on` = 0, and a software conversion works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Software conversion path enable |
| sw_chan | input | 4 | Software channel select |
| sw_start_wr | input | 1 | One-cycle write of 1 to the start bit |
| ext_delay | input | 1 | Long acquisition for software jobs |
| force_on | input | 1 | Hold converter power while idle |
| eoc_mask | input | 1 | Masks the end-of-conversion interrupt |
| auto_en | input | 2 | Per-slot automatic enable |
| auto_run | input | 2 | Per-slot run bit; clearing stops the slot |
| auto_chan | input | 8 | Per-slot channel, 4 bits per slot |
| core_done | input | 1 | Converter done strobe |
| core_data | input | 12 | Converter output code |
| core_start | output | 1 | Start strobe to the converter |
| core_chan | output | 4 | Channel to the converter multiplexer |
| avail | output | 1 | 1 when no job is in progress |
| pwr_on | output | 1 | Converter power request |
| start_bit | output | 1 | Software start bit read-back |
| sw_res_lo | output | 8 | Software result, low byte |
| sw_res_hi | output | 8 | Software result, high byte (upper nibble 0) |
| auto_res | output | 24 | Automatic results, 12 bits per slot |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
The bench goes after cancellations at both points of a job. Disabling a slot mid-conversion must drop the job only when the core answers; a design that returned to idle early would accept the stray done strobe as the next job's result. A design that never left the busy state would keep `avail` low for good. A software start written while two slot requests are pending checks arbitration order; a wrong order shows up as the wrong channel on the next start pulse. The stop sequence with the power hold is run after a slot has been cut off mid-job, and a software start written while `sw_en` is low must leave the start bit clear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_CONV  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;

  function automatic logic [BYTE_W-1:0] lo_byte(input logic [RES_W-1:0] code);
    return code[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] hi_byte(input logic [RES_W-1:0] code);
    logic [BYTE_W-1:0] h;
    h = '0;
    h[RES_W-BYTE_W-1:0] = code[RES_W-1:BYTE_W];
    return h;
  endfunction

  function automatic int unsigned acq_len(input logic use_long,
                                          input int unsigned short_clks,
                                          input int unsigned long_clks);
    return use_long ? long_clks : short_clks;
  endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int N_AUTO      = 2,
  parameter int AUTO_PERIOD = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic              sw_start_wr,
  input  logic              sw_done,
  input  logic [N_AUTO-1:0] slot_act,
  input  logic [N_AUTO-1:0] slot_launch,
  output logic              start_bit,
  output logic [N_AUTO-1:0] pend
);

  localparam int PCNT_W = (AUTO_PERIOD > 1) ? $clog2(AUTO_PERIOD) : 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(AUTO_PERIOD - 1);

  logic [PCNT_W-1:0] pcnt;
  logic              any_act;
  logic              period_tick;

  assign any_act     = |slot_act;
  assign period_tick = any_act && (pcnt == PCNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                 pcnt <= '0;
    else if (!any_act)          pcnt <= '0;
    else if (pcnt == PCNT_LAST) pcnt <= '0;
    else                        pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           start_bit <= 1'b0;
    else if (!sw_en)      start_bit <= 1'b0;
    else if (sw_start_wr) start_bit <= 1'b1;
    else if (sw_done)     start_bit <= 1'b0;
  end

  for (genvar g = 0; g < N_AUTO; g++) begin : g_slot
    logic pend_q;
    always_ff @(posedge clk) begin
      if (!rst_n)               pend_q <= 1'b0;
      else if (!slot_act[g])    pend_q <= 1'b0;
      else if (period_tick)     pend_q <= 1'b1;
      else if (slot_launch[g])  pend_q <= 1'b0;
    end
    assign pend[g] = pend_q;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W       = 4,
  parameter int N_AUTO       = 2,
  parameter int SLOT_W       = (N_AUTO > 1) ? $clog2(N_AUTO) : 1,
  parameter int ACQ_CLKS     = 16,
  parameter int ACQ_EXT_CLKS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_bit,
  input  logic                     sw_en,
  input  logic [CHAN_W-1:0]        sw_chan,
  input  logic                     ext_delay,
  input  logic [N_AUTO-1:0]        pend,
  input  logic [N_AUTO-1:0]        slot_act,
  input  logic [N_AUTO*CHAN_W-1:0] auto_chan,
  input  logic                     core_done,
  output seq_state_e               state,
  output logic                     core_start,
  output logic [CHAN_W-1:0]        core_chan,
  output logic [N_AUTO-1:0]        slot_launch,
  output logic                     job_sw,
  output logic [SLOT_W-1:0]        job_slot,
  output logic                     ev_launch,
  output logic                     ev_abort,
  output logic                     ev_finish
);

  localparam int ACQ_MAX = (ACQ_EXT_CLKS > ACQ_CLKS) ? ACQ_EXT_CLKS : ACQ_CLKS;
  localparam int CNT_W   = (ACQ_MAX > 1) ? $clog2(ACQ_MAX) : 1;
  localparam logic [CNT_W-1:0] AUTO_LOAD = CNT_W'(ACQ_CLKS - 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  sw_load;
  logic              sw_go;
  logic              a_go;
  logic [SLOT_W-1:0] a_sel;
  logic              job_ok;

  assign sw_go   = start_bit && sw_en;
  assign sw_load = CNT_W'(acq_len(ext_delay, ACQ_CLKS, ACQ_EXT_CLKS) - 1);
  assign job_ok  = job_sw ? sw_en : slot_act[job_slot];

  always_comb begin
    a_go  = 1'b0;
    a_sel = '0;
    for (int i = N_AUTO - 1; i >= 0; i--) begin
      if (pend[i] && slot_act[i]) begin
        a_go  = 1'b1;
        a_sel = SLOT_W'(i);
      end
    end
  end

  for (genvar g = 0; g < N_AUTO; g++) begin : g_launch
    assign slot_launch[g] = (state == ST_IDLE) && !sw_go && a_go && (a_sel == SLOT_W'(g));
  end

  assign ev_launch = (state == ST_IDLE) && (sw_go || a_go);
  assign ev_abort  = ((state == ST_ACQ) || (state == ST_CONV)) && !job_ok;
  assign ev_finish = (state == ST_CONV) && job_ok && core_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      job_sw     <= 1'b0;
      job_slot   <= '0;
      core_chan  <= '0;
      core_start <= 1'b0;
    end else begin
      core_start <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (sw_go) begin
            state     <= ST_ACQ;
            job_sw    <= 1'b1;
            core_chan <= sw_chan;
            cnt       <= sw_load;
          end else if (a_go) begin
            state     <= ST_ACQ;
            job_sw    <= 1'b0;
            job_slot  <= a_sel;
            core_chan <= auto_chan[a_sel*CHAN_W +: CHAN_W];
            cnt       <= AUTO_LOAD;
          end
        end
        ST_ACQ: begin
          if (!job_ok) begin
            state <= ST_IDLE;
          end else if (cnt == '0) begin
            state      <= ST_CONV;
            core_start <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (!job_ok)        state <= core_done ? ST_IDLE : ST_DRAIN;
          else if (core_done) state <= ST_IDLE;
        end
        ST_DRAIN: begin
          if (core_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_res.sv
module adc_seq_res
  import adc_seq_pkg::*;
#(
  parameter int N_AUTO = 2,
  parameter int SLOT_W = (N_AUTO > 1) ? $clog2(N_AUTO) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_finish,
  input  logic                    job_sw,
  input  logic [SLOT_W-1:0]       job_slot,
  input  logic [RES_W-1:0]        core_data,
  input  logic                    eoc_mask,
  output logic [BYTE_W-1:0]       sw_res_lo,
  output logic [BYTE_W-1:0]       sw_res_hi,
  output logic [N_AUTO*RES_W-1:0] auto_res,
  output logic                    eoc_irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_res_lo <= '0;
      sw_res_hi <= '0;
      eoc_irq   <= 1'b0;
    end else begin
      eoc_irq <= ev_finish && job_sw && !eoc_mask;
      if (ev_finish && job_sw) begin
        sw_res_lo <= lo_byte(core_data);
        sw_res_hi <= hi_byte(core_data);
      end
    end
  end

  for (genvar g = 0; g < N_AUTO; g++) begin : g_ares
    logic [RES_W-1:0] res_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        res_q <= '0;
      else if (ev_finish && !job_sw && (job_slot == SLOT_W'(g)))
        res_q <= core_data;
    end
    assign auto_res[g*RES_W +: RES_W] = res_q;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W       = 4,
  parameter int N_AUTO       = 2,
  parameter int ACQ_CLKS     = 16,
  parameter int ACQ_EXT_CLKS = 64,
  parameter int AUTO_PERIOD  = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_en,
  input  logic [CHAN_W-1:0]        sw_chan,
  input  logic                     sw_start_wr,
  input  logic                     ext_delay,
  input  logic                     force_on,
  input  logic                     eoc_mask,
  input  logic [N_AUTO-1:0]        auto_en,
  input  logic [N_AUTO-1:0]        auto_run,
  input  logic [N_AUTO*CHAN_W-1:0] auto_chan,
  input  logic                     core_done,
  input  logic [RES_W-1:0]         core_data,
  output logic                     core_start,
  output logic [CHAN_W-1:0]        core_chan,
  output logic                     avail,
  output logic                     pwr_on,
  output logic                     start_bit,
  output logic [BYTE_W-1:0]        sw_res_lo,
  output logic [BYTE_W-1:0]        sw_res_hi,
  output logic [N_AUTO*RES_W-1:0]  auto_res,
  output logic                     eoc_irq
);

  localparam int SLOT_W = (N_AUTO > 1) ? $clog2(N_AUTO) : 1;

  seq_state_e        state;
  logic [N_AUTO-1:0] slot_act;
  logic [N_AUTO-1:0] slot_launch;
  logic [N_AUTO-1:0] pend;
  logic              job_sw;
  logic [SLOT_W-1:0] job_slot;
  logic              ev_launch;
  logic              ev_abort;
  logic              ev_finish;
  logic              sw_done;

  assign slot_act = auto_en & auto_run;
  assign sw_done  = ev_finish && job_sw;
  assign avail    = (state == ST_IDLE);
  assign pwr_on   = force_on || !avail;

  adc_seq_trig #(
    .N_AUTO      (N_AUTO),
    .AUTO_PERIOD (AUTO_PERIOD)
  ) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_en       (sw_en),
    .sw_start_wr (sw_start_wr),
    .sw_done     (sw_done),
    .slot_act    (slot_act),
    .slot_launch (slot_launch),
    .start_bit   (start_bit),
    .pend        (pend)
  );

  adc_seq_fsm #(
    .CHAN_W       (CHAN_W),
    .N_AUTO       (N_AUTO),
    .SLOT_W       (SLOT_W),
    .ACQ_CLKS     (ACQ_CLKS),
    .ACQ_EXT_CLKS (ACQ_EXT_CLKS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_bit   (start_bit),
    .sw_en       (sw_en),
    .sw_chan     (sw_chan),
    .ext_delay   (ext_delay),
    .pend        (pend),
    .slot_act    (slot_act),
    .auto_chan   (auto_chan),
    .core_done   (core_done),
    .state       (state),
    .core_start  (core_start),
    .core_chan   (core_chan),
    .slot_launch (slot_launch),
    .job_sw      (job_sw),
    .job_slot    (job_slot),
    .ev_launch   (ev_launch),
    .ev_abort    (ev_abort),
    .ev_finish   (ev_finish)
  );

  adc_seq_res #(
    .N_AUTO (N_AUTO),
    .SLOT_W (SLOT_W)
  ) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_finish (ev_finish),
    .job_sw    (job_sw),
    .job_slot  (job_slot),
    .core_data (core_data),
    .eoc_mask  (eoc_mask),
    .sw_res_lo (sw_res_lo),
    .sw_res_hi (sw_res_hi),
    .auto_res  (auto_res),
    .eoc_irq   (eoc_irq)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int ACQ_CLKS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_en,
  input logic       eoc_mask,
  input logic       core_done,
  input logic       core_start,
  input logic       avail,
  input logic       start_bit,
  input logic       eoc_irq,
  input logic [7:0] sw_res_lo,
  input logic [7:0] sw_res_hi,
  input logic       ev_launch,
  input logic       ev_abort
);

  localparam int BUSY_W = 8;
  localparam logic [BUSY_W-1:0] BUSY_SAT = '1;

  logic [BUSY_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || avail)        busy_cnt <= '0;
    else if (busy_cnt != BUSY_SAT) busy_cnt <= busy_cnt + 1'b1;
  end

  a_r5_launch_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> !avail);

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  a_r2_start_after_acq: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (!avail && $past(!avail)));

  a_r2_acq_window: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (busy_cnt >= BUSY_W'(ACQ_CLKS)));

  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(core_done) |-> ($stable(sw_res_lo) && $stable(sw_res_hi)));

  a_r4_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  a_r4_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> ($past(core_done) && !$past(eoc_mask)));

  a_r7_start_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !start_bit);

  a_r10_abort_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_abort && core_done) |=> avail);

endmodule

bind adc_seq_ctrl adc_seq_chk #(.ACQ_CLKS(ACQ_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_en      (sw_en),
  .eoc_mask   (eoc_mask),
  .core_done  (core_done),
  .core_start (core_start),
  .avail      (avail),
  .start_bit  (start_bit),
  .eoc_irq    (eoc_irq),
  .sw_res_lo  (sw_res_lo),
  .sw_res_hi  (sw_res_hi),
  .ev_launch  (ev_launch),
  .ev_abort   (ev_abort)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

  localparam int CHAN_W      = 4;
  localparam int N_AUTO      = 2;
  localparam int ACQ_N       = 16;
  localparam int ACQ_X       = 64;
  localparam int AUTO_PERIOD = 200;
  localparam int CORE_LAT    = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_en = 1'b0;
  logic [3:0]  sw_chan = '0;
  logic        sw_start_wr = 1'b0;
  logic        ext_delay = 1'b0;
  logic        force_on = 1'b0;
  logic        eoc_mask = 1'b0;
  logic [1:0]  auto_en = '0;
  logic [1:0]  auto_run = '0;
  logic [7:0]  auto_chan = '0;
  logic        core_done = 1'b0;
  logic [11:0] core_data = '0;
  logic        core_start;
  logic [3:0]  core_chan;
  logic        avail;
  logic        pwr_on;
  logic        start_bit;
  logic [7:0]  sw_res_lo;
  logic [7:0]  sw_res_hi;
  logic [23:0] auto_res;
  logic        eoc_irq;

  always #5 clk = ~clk;

  adc_seq_ctrl #(
    .CHAN_W(CHAN_W), .N_AUTO(N_AUTO), .ACQ_CLKS(ACQ_N),
    .ACQ_EXT_CLKS(ACQ_X), .AUTO_PERIOD(AUTO_PERIOD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .sw_chan(sw_chan),
    .sw_start_wr(sw_start_wr), .ext_delay(ext_delay), .force_on(force_on),
    .eoc_mask(eoc_mask), .auto_en(auto_en), .auto_run(auto_run),
    .auto_chan(auto_chan), .core_done(core_done), .core_data(core_data),
    .core_start(core_start), .core_chan(core_chan), .avail(avail),
    .pwr_on(pwr_on), .start_bit(start_bit), .sw_res_lo(sw_res_lo),
    .sw_res_hi(sw_res_hi), .auto_res(auto_res), .eoc_irq(eoc_irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // ---------------- behavioural reference (job-level view) ----------------
  int m_phase = 0;   // 0 idle, 1 settling, 2 converting, 3 discarding
  int m_left = 0, m_who = 0, m_ch = 0, m_per = 0;
  int m_start = 0, m_strobe = 0, m_irq = 0, m_lo = 0, m_hi = 0;
  int m_ares[2] = '{0, 0};
  int m_req[2]  = '{0, 0};

  always @(posedge clk) begin : ref_model
    int run[2];
    int tick, ok, next_phase, picked, fin_sw;
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_who = 0; m_ch = 0; m_per = 0;
      m_start = 0; m_strobe = 0; m_irq = 0; m_lo = 0; m_hi = 0;
      m_ares[0] = 0; m_ares[1] = 0; m_req[0] = 0; m_req[1] = 0;
    end else begin
      run[0] = auto_en[0] & auto_run[0];
      run[1] = auto_en[1] & auto_run[1];
      tick = 0;
      if (run[0] == 0 && run[1] == 0) m_per = 0;
      else if (m_per == AUTO_PERIOD - 1) begin m_per = 0; tick = 1; end
      else m_per = m_per + 1;
      ok = (m_who < 0) ? int'(sw_en) : run[m_who];
      next_phase = m_phase; picked = -1; fin_sw = 0;
      m_strobe = 0; m_irq = 0;
      if (m_phase == 0) begin
        if (m_start != 0 && sw_en) begin
          next_phase = 1; m_who = -1; m_ch = sw_chan;
          m_left = (ext_delay ? ACQ_X : ACQ_N) - 1;
        end else begin
          for (int k = 1; k >= 0; k--)
            if (m_req[k] != 0 && run[k] != 0) picked = k;
          if (picked >= 0) begin
            next_phase = 1; m_who = picked;
            m_ch = (auto_chan >> (4 * picked)) & 15;
            m_left = ACQ_N - 1;
          end
        end
      end else if (m_phase == 1) begin
        if (ok == 0) next_phase = 0;
        else if (m_left == 0) begin next_phase = 2; m_strobe = 1; end
        else m_left = m_left - 1;
      end else if (m_phase == 2) begin
        if (ok == 0) next_phase = core_done ? 0 : 3;
        else if (core_done) begin
          next_phase = 0;
          if (m_who < 0) begin
            m_lo = core_data & 255; m_hi = core_data >> 8;
            fin_sw = 1; m_irq = eoc_mask ? 0 : 1;
          end else m_ares[m_who] = core_data;
        end
      end else begin
        if (core_done) next_phase = 0;
      end
      for (int k = 0; k < 2; k++) begin
        if (run[k] == 0) m_req[k] = 0;
        else if (tick != 0) m_req[k] = 1;
        else if (picked == k) m_req[k] = 0;
      end
      if (!sw_en) m_start = 0;
      else if (sw_start_wr) m_start = 1;
      else if (fin_sw != 0) m_start = 0;
      m_phase = next_phase;
    end
  end

  // ---------------- per-cycle comparison and converter model ----------------
  int core_wait = -1;
  int core_seq  = 0;
  int core_ch   = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check_eq("R5", "avail", int'(avail), (m_phase == 0) ? 1 : 0);
      check_eq("R6", "pwr_on", int'(pwr_on), (force_on || m_phase != 0) ? 1 : 0);
      check_eq("R2", "core_start", int'(core_start), m_strobe);
      if (m_strobe != 0) check_eq("R1", "core_chan", int'(core_chan), m_ch);
      check_eq("R4", "eoc_irq", int'(eoc_irq), m_irq);
      check_eq("R3", "sw_res_lo", int'(sw_res_lo), m_lo);
      check_eq("R3", "sw_res_hi", int'(sw_res_hi), m_hi);
      check_eq("R8", "auto_res slot0", int'(auto_res[11:0]), m_ares[0]);
      check_eq("R8", "auto_res slot1", int'(auto_res[23:12]), m_ares[1]);
      check_eq("R7", "start_bit", int'(start_bit), m_start);
      core_done = 1'b0;
      if (core_wait == 0) begin
        core_done = 1'b1;
        core_data = 12'((core_ch << 8) | ((core_seq * 37) & 255));
        core_wait = -1;
      end else if (core_wait > 0) begin
        core_wait--;
      end
      if (core_start) begin
        core_wait = CORE_LAT - 1;
        core_ch   = int'(core_chan);
        core_seq++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_go(input int ch);
    @(negedge clk); #1;
    sw_chan = 4'(ch); sw_en = 1'b1; sw_start_wr = 1'b1;
    @(negedge clk); #1;
    sw_start_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int lim = 0;
    repeat (2) @(negedge clk);
    while (!avail && lim < 2000) begin @(negedge clk); lim++; end
  endtask

  task automatic wait_strobe(output int ch);
    int lim = 0;
    @(negedge clk);
    while (!core_start && lim < 2000) begin @(negedge clk); lim++; end
    ch = int'(core_chan);
  endtask

  task automatic sw_latency(input int ch, input int exp, input string req);
    int lat = 0;
    @(negedge clk); #1;
    sw_chan = 4'(ch); sw_en = 1'b1; sw_start_wr = 1'b1;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      lat = i;
      if (core_start) break;
      #1 sw_start_wr = 1'b0;
    end
    sw_start_wr = 1'b0;
    check_eq(req, "start-to-strobe latency", lat, exp);
  endtask

  initial begin
    int ch, save_lo, save_hi, save_a0;
    idle(4);
    // reset state
    check_eq("R5", "avail in reset", int'(avail), 1);
    check_eq("R7", "start_bit in reset", int'(start_bit), 0);
    check_eq("R3", "sw_res_lo in reset", int'(sw_res_lo), 0);
    check_eq("R4", "eoc_irq in reset", int'(eoc_irq), 0);
    #1 rst_n = 1'b1;
    idle(3);

    // R1/R2: short acquisition, then long acquisition
    sw_latency(5, ACQ_N + 2, "R2");
    wait_idle();
    check_eq("R3", "high byte carries bits 11..8", int'(sw_res_hi), 5);
    #1 ext_delay = 1'b1;
    sw_latency(9, ACQ_X + 2, "R2");
    wait_idle();
    #1 ext_delay = 1'b0;

    // R4: masked completion
    #1 eoc_mask = 1'b1;
    sw_go(3);
    wait_idle();
    #1 eoc_mask = 1'b0;

    // R7: start write while disabled is ignored
    @(negedge clk); #1 sw_en = 1'b0; sw_start_wr = 1'b1;
    @(negedge clk); #1 sw_start_wr = 1'b0;
    idle(2);
    check_eq("R7", "start ignored while disabled", int'(start_bit), 0);
    check_eq("R7", "no job launched while disabled", int'(avail), 1);

    // R7: cancel during acquisition
    save_lo = int'(sw_res_lo); save_hi = int'(sw_res_hi);
    sw_go(7);
    idle(5);
    #1 sw_en = 1'b0;
    idle(2);
    check_eq("R7", "idle after cancel in settling", int'(avail), 1);
    check_eq("R7", "start cleared by cancel", int'(start_bit), 0);
    check_eq("R7", "low byte kept after cancel", int'(sw_res_lo), save_lo);

    // R10-style drain for a software job cancelled during conversion
    sw_go(8);
    wait_strobe(ch);
    #1 sw_en = 1'b0;
    wait_idle();
    check_eq("R7", "high byte kept after late cancel", int'(sw_res_hi), save_hi);
    sw_go(8);
    wait_idle();
    check_eq("R3", "result after drained job", int'(sw_res_hi), 8);

    // R8/R9: two automatic slots plus a software start
    @(negedge clk); #1 auto_chan = {4'd11, 4'd2}; auto_en = 2'b11; auto_run = 2'b11;
    wait_strobe(ch);
    check_eq("R9", "slot 0 served before slot 1", ch, 2);
    wait_strobe(ch);
    check_eq("R8", "slot 1 served in same period", ch, 11);
    wait_strobe(ch);
    check_eq("R8", "slot 0 served next period", ch, 2);
    sw_go(6);
    wait_strobe(ch);
    check_eq("R9", "software start beats pending slot 1", ch, 6);
    wait_strobe(ch);
    check_eq("R9", "slot 1 served after software", ch, 11);

    // R10: drop slot 0 in the middle of its conversion
    ch = 0;
    while (ch != 2) wait_strobe(ch);
    save_a0 = int'(auto_res[11:0]);
    #1 auto_run[0] = 1'b0;
    wait_idle();
    check_eq("R10", "idle after slot dropped", int'(avail), 1);
    check_eq("R10", "dropped code discarded", int'(auto_res[11:0]), save_a0);
    idle(450);
    #1 auto_run[0] = 1'b1;
    wait_strobe(ch);

    // R11: power-hold stop sequence with a job in flight
    @(negedge clk); #1 force_on = 1'b1; auto_run = 2'b00;
    idle(100);
    #1 force_on = 1'b0;
    idle(10);
    check_eq("R11", "avail after stop sequence", int'(avail), 1);
    check_eq("R6", "power released after stop", int'(pwr_on), 0);
    sw_go(12);
    wait_idle();
    check_eq("R11", "conversion after stop sequence", int'(sw_res_hi), 12);

    // R6: hold while idle
    @(negedge clk); #1 force_on = 1'b1;
    @(negedge clk);
    check_eq("R6", "power held while idle", int'(pwr_on), 1);
    check_eq("R6", "hold does not make busy", int'(avail), 1);
    #1 force_on = 1'b0;
    idle(5);

    summary();
    $finish;
  end

endmodule